// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes configuration bytes from a three-wire serial link (a bit clock, a bit line and a commit strobe) and writes them into a small bank of configuration registers that drive downstream logic in parallel. The serial inputs are not used as clocks. All three are brought into the system clock domain through a synchronizer chain, and edges of the bit clock and of the strobe are found there.

Bits enter a shift register with the most significant bit first. When the commit strobe rises, the eight bits now held in the shift register form a word. The top three bits of that word pick one of eight registers, and the low five bits become its new value. Bits shifted before the last eight fall out of the shift register and have no effect. A high level on the master reset clears every register and the shift register at once, with no clock edge needed.

Top module: `cfg_serial_loader`

## Requirements
- R1: The bit line is sampled only at a rising edge of the serial bit clock. A change on the bit line while the bit clock is high, and the falling edge that follows, shift nothing.
- R2: Bits are shifted in most significant bit first. The first of eight bits ends up in word bit 7.
- R3: A rising edge of the commit strobe writes the eight most recently shifted bits. Any bits shifted before those eight have no effect.
- R4: Word bits [7:5] select register 0 to 7. Word bits [4:0] become that register's value. Register i appears on `cfg_regs[i*5 +: 5]`. All other registers keep their values.
- R5: If fewer than eight bits were shifted since the previous commit, a commit still writes the whole current shift-register contents. These include bits left from earlier transfers.
- R6: While `rst` is high, every register and the shift register are zero, and this takes effect without any clock edge. Each register's default is zero.
- R7: Registers change only on a rising edge of the commit strobe. Holding the strobe high while bits shift does not commit them, and the falling edge of the strobe writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous master reset, active high |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial bit line, MSB first |
| ser_lat | input | 1 | Commit strobe, acts on its rising edge |
| cfg_regs | output | 40 | All eight 5-bit registers, register i at bits [i*5 +: 5] |

## Verification
The assertions check on every cycle that the edge pulses last only one cycle, that the shift register moves exactly one place per detected bit-clock edge and holds otherwise, that a write lands its payload in the addressed register, that the bank stays unchanged when no write occurs, and that the bank is zero whenever reset is high. Other behaviour depends on a sequence of serial events, and only the bench scenarios can show it. This covers dropping bits shifted before the last eight, committing a partly refilled shift register, ignoring a held or falling strobe, ignoring data changes during the bit clock's high phase, and reset clearing the shift register as well as the bank.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   // Fewest flops allowed in a synchronizer chain
   localparam int unsigned CFGL_MIN_SYNC = 2;
   // Width of one serial word
   localparam int unsigned CFGL_WORD_W   = 8;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
         if (rst) chain[s] <= '0;
         else     chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgl_edge.sv
module cfgl_edge (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev <= 1'b0;
      else     prev <= level;
   end

   assign rise = level & ~prev;

   // R7: one pulse per edge, never two cycles in a row
   p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] sr
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)           sr <= '0;
      else if (shift_en) sr <= {sr[WIDTH-2:0], din};
   end

   // R1: no bit-clock edge, no movement
   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(sr));
   // R2: new bit enters at the bottom, older bits move toward the MSB
   p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (sr[0] == $past(din)) && (sr[WIDTH-1:1] == $past(sr[WIDTH-2:0])));
endmodule

// File: rtl/cfgl_regfile.sv
module cfgl_regfile #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 5
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [ADDR_W+DATA_W-1:0]        wr_word,
   output logic [(1<<ADDR_W)*DATA_W-1:0]   regs_flat
);
   localparam int unsigned NREG = 1 << ADDR_W;

   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   assign wr_addr = wr_word[ADDR_W+DATA_W-1:DATA_W];
   assign wr_data = wr_word[DATA_W-1:0];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                                      r <= '0;
         else if (wr_en && wr_addr == ADDR_W'(i))      r <= wr_data;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = r;
   end

   // R4: a write lands its payload in the addressed slot
   p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> regs_flat[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data));
   // R7: without a write, the bank does not move
   p_bank_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 5
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          ser_clk,
   input  logic                          ser_dat,
   input  logic                          ser_lat,
   output logic [(1<<ADDR_W)*DATA_W-1:0] cfg_regs
);
   import cfgl_pkg::*;

   localparam int unsigned WORD_W = ADDR_W + DATA_W;

   if (SYNC_STAGES < CFGL_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES must be at least %0d", CFGL_MIN_SYNC);
   end
   if (WORD_W != CFGL_WORD_W) begin : g_bad_word
      $error("ADDR_W + DATA_W must equal %0d", CFGL_WORD_W);
   end

   // All three lines share one chain so data stays aligned with its clock
   logic [2:0] sync_q;
   cfgl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ser_lat, ser_clk, ser_dat}),
      .q   (sync_q)
   );

   logic bit_rise, lat_rise;
   cfgl_edge u_bit_edge (.clk(clk), .rst(rst), .level(sync_q[1]), .rise(bit_rise));
   cfgl_edge u_lat_edge (.clk(clk), .rst(rst), .level(sync_q[2]), .rise(lat_rise));

   logic [WORD_W-1:0] shreg;
   cfgl_shifter #(.WIDTH(WORD_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (bit_rise),
      .din      (sync_q[0]),
      .sr       (shreg)
   );

   cfgl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (lat_rise),
      .wr_word   (shreg),
      .regs_flat (cfg_regs)
   );

   // R6: reset holds every register at its zero default
   p_reset_clear_r6: assert property (@(posedge clk)
      rst |-> (cfg_regs == '0) && (shreg == '0));
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int DW = 5;

   logic clk = 1'b0, rst = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
   logic [NREG*DW-1:0] cfg_regs;

   cfg_serial_loader dut (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_lat(ser_lat), .cfg_regs(cfg_regs)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;
   logic [7:0] m_sr = '0;
   logic [DW-1:0] m_reg [NREG];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic put_bit(bit b);
      ser_dat = b; step(3);
      ser_clk = 1'b1; step(4);
      ser_clk = 1'b0; step(3);
      m_sr = {m_sr[6:0], b};
   endtask

   task automatic put_byte(logic [7:0] v);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
   endtask

   task automatic commit();
      ser_lat = 1'b1; step(5);
      ser_lat = 1'b0; step(5);
      m_reg[m_sr[7:5]] = m_sr[4:0];
   endtask

   function automatic logic [DW-1:0] model_word_payload(logic [7:0] w);
      return w[4:0];
   endfunction

   task automatic check_bank(string req);
      bit bad = 1'b0;
      n_chk++;
      for (int i = 0; i < NREG; i++) begin
         if (cfg_regs[i*DW +: DW] !== m_reg[i]) begin
            bad = 1'b1;
            $display("FAIL %s reg%0d: actual %h expected %h", req, i,
                     cfg_regs[i*DW +: DW], m_reg[i]);
         end
      end
      if (bad) n_fail++;
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      void'($urandom(32'h5EED_0C0F));
      step(4);
      // R6: defaults out of reset
      check_bank("R6 reset defaults");
      rst = 1'b0; step(3);
      check_bank("R6 after release");

      // R2 R4: one byte, addr 5, payload 10110
      put_byte(8'b101_10110); commit();
      check_bank("R2 R4 single byte");
      if (m_reg[5] !== model_word_payload(8'b101_10110)) $display("model error");

      // R3: twelve bits, only the last eight count
      put_bit(1); put_bit(1); put_bit(1); put_bit(1);
      put_byte(8'b010_01001); commit();
      check_bank("R3 extra leading bits");

      // R5: only three new bits since the last commit
      put_bit(0); put_bit(1); put_bit(1); commit();
      check_bank("R5 partial refill");

      // R7: strobe held high while a byte shifts, then released
      put_byte(8'b110_11100);
      ser_lat = 1'b1; step(5);
      m_reg[m_sr[7:5]] = m_sr[4:0];
      put_byte(8'b011_00111);
      check_bank("R7 held strobe no commit");
      ser_lat = 1'b0; step(6);
      check_bank("R7 falling edge no commit");
      commit();
      check_bank("R7 next rising edge commits");

      // R1: data changes while bit clock is high; falling edge must not sample
      ser_dat = 1'b1; step(3);
      ser_clk = 1'b1; step(4);
      ser_dat = 1'b0; step(3);
      ser_clk = 1'b0; step(3);
      m_sr = {m_sr[6:0], 1'b1};
      put_bit(0); put_bit(0); put_bit(1); put_bit(0); put_bit(1); put_bit(0); put_bit(1);
      commit();
      check_bank("R1 rising edge only");

      // R6: asynchronous reset mid-run, between clock edges
      put_byte(8'hFF);
      @(posedge clk); #2;
      rst = 1'b1; #1;
      for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      m_sr = '0;
      check_bank("R6 async clear no clock");
      step(2); rst = 1'b0; step(3);
      put_bit(1); put_bit(1); put_bit(1); commit();
      check_bank("R6 shift register cleared");

      // R3 R4: random bytes with random leading junk
      for (int it = 0; it < 40; it++) begin
         int k;
         k = $urandom_range(0, 4);
         for (int j = 0; j < k; j++) put_bit(1'($urandom));
         put_byte(8'($urandom));
         commit();
         check_bank("R3 R4 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule